// File: doc/BRIEF.md
# Indexed Configuration Register Bank

This block gives a host two small register files, each reached through a pair of bus locations: one holds an index and one moves data to or from the entry that the index picks. The byte file holds 256 eight-bit entries. Its entry 0 acts as a rolling counter: every read of it returns the stored value and then advances that value by 0x40.

The word file holds four 16-bit words behind each of 256 indexes. A hidden two-bit sub-pointer picks which of the four words a data access reaches. Writing the word index clears the sub-pointer. Every completed data access, read or write, then moves it on by one, wrapping after the fourth word. A host can therefore stream all four words of one index without rewriting the index.

Accesses are synchronous to the clock. A read strobe returns its data on `acc_rdata` one cycle later, and the output keeps that value until the next read.

Top module: `cfg_index_bank`

## Requirements
- R1: Location 0 is the byte-file index. A write stores `acc_wdata[7:0]`, and a read returns the stored index zero-extended to 16 bits.
- R2: Location 1 is byte-file data. A write stores `acc_wdata[7:0]` in the entry selected by the byte index. A read returns that entry zero-extended. Entries at different indexes keep separate values.
- R3: A read of location 1 while the byte index is 0 returns the stored value. Afterwards entry 0 holds that value plus 0x40, modulo 256. A write to entry 0 only stores the written value.
- R4: After reset every byte entry is 0 except entry 0, which is 0x10, and the byte index is 0.
- R5: Location 2 is the word-file index. A write stores `acc_wdata[7:0]` as the index and sets the sub-pointer to 0. A read returns the index zero-extended.
- R6: Location 3 is word-file data. Each read or write there reaches word number sub-pointer of the current index, then increments the sub-pointer modulo 4. A fifth access after an index write reaches word 0 again.
- R7: After reset every word entry, the word index and the sub-pointer are 0.
- R8: A read strobe held for one cycle is one access. `acc_rdata` takes the read value on the clock edge after the strobe and does not change in cycles with no read.
- R9: If `acc_rd` and `acc_wr` are both high in the same cycle, only the write takes place. `acc_rdata` keeps its value, entry 0 gets no 0x40 step, and the sub-pointer advances once.
- R10: Only the sub-pointer steps on word-data accesses. Reads of the two index locations never change any stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 2 | Location select: 0 byte index, 1 byte data, 2 word index, 3 word data |
| acc_wr | input | 1 | Write strobe, one access per high cycle |
| acc_rd | input | 1 | Read strobe, one access per high cycle |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid the cycle after a read strobe |

## Verification
The byte file is tried with scattered indexes written with distinct values, which separates correct index decoding from aliasing. It is also tried with repeated reads of entry 0, five in a row, so the 0x40 step and its wrap back to 0x10 are both seen. The word file is written as four words in a stream, re-indexed, then read back in order and once more past the fourth word. This shows the sub-pointer's order, its clearing on an index write and its wrap. Simultaneous read and write strobes on both data locations, followed by plain reads, show that a conflicting access counts once and never acts as a read.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

    localparam int IDX_W   = 8;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int SUBS    = 4;
    localparam int BUS_W   = 16;

    typedef enum logic [1:0] {
        SEL_BIDX = 2'd0,
        SEL_BDAT = 2'd1,
        SEL_WIDX = 2'd2,
        SEL_WDAT = 2'd3
    } sel_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        sel_e             sel;
        logic [BUS_W-1:0] data;
    } acc_t;

    // A write wins over a read strobed in the same cycle.
    function automatic acc_t make_req(input logic wr, input logic rd,
                                      input logic [1:0] addr,
                                      input logic [BUS_W-1:0] data);
        acc_t r;
        r.wr   = wr;
        r.rd   = rd & ~wr;
        r.sel  = sel_e'(addr);
        r.data = data;
        return r;
    endfunction

endpackage

// File: rtl/cfg_byte_file.sv
module cfg_byte_file
    import cfg_bank_pkg::*;
#(
    parameter int                DEPTH = 256,
    parameter logic [BYTE_W-1:0] SEED0 = 8'h10,
    parameter logic [BYTE_W-1:0] BUMP  = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              req,
    output logic [BYTE_W-1:0] rd_val
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0]     idx_q;
    logic [BYTE_W-1:0] mem_q [DEPTH];

    wire hit_idx_wr = req.wr && req.sel == SEL_BIDX;
    wire hit_dat_wr = req.wr && req.sel == SEL_BDAT;
    wire hit_dat_rd = req.rd && req.sel == SEL_BDAT;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= (i == 0) ? SEED0 : '0;
        end else begin
            if (hit_idx_wr)
                idx_q <= req.data[AW-1:0];
            if (hit_dat_wr)
                mem_q[idx_q] <= req.data[BYTE_W-1:0];
            else if (hit_dat_rd && idx_q == '0)
                mem_q[0] <= mem_q[0] + BUMP;
        end
    end

    always_comb begin
        if (req.sel == SEL_BIDX)
            rd_val = BYTE_W'(idx_q);
        else
            rd_val = mem_q[idx_q];
    end

    p_zero_bump_r3: assert property (@(posedge clk) disable iff (rst)
        (hit_dat_rd && idx_q == '0) |=> (mem_q[0] == $past(mem_q[0]) + BUMP));

    p_idx_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !hit_idx_wr |=> $stable(idx_q));

endmodule

// File: rtl/cfg_word_file.sv
module cfg_word_file
    import cfg_bank_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int NSUB  = SUBS
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              req,
    output logic [WORD_W-1:0] rd_val
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(NSUB);

    logic [AW-1:0]     idx_q;
    logic [PW-1:0]     ptr_q;
    logic [WORD_W-1:0] mem_q [NSUB][DEPTH];

    wire hit_idx_wr = req.wr && req.sel == SEL_WIDX;
    wire hit_dat    = (req.wr || req.rd) && req.sel == SEL_WDAT;
    wire hit_dat_wr = req.wr && req.sel == SEL_WDAT;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            ptr_q <= '0;
            for (int s = 0; s < NSUB; s++)
                for (int i = 0; i < DEPTH; i++)
                    mem_q[s][i] <= '0;
        end else begin
            if (hit_idx_wr) begin
                idx_q <= req.data[AW-1:0];
                ptr_q <= '0;
            end else if (hit_dat) begin
                ptr_q <= ptr_q + PW'(1);
            end
            if (hit_dat_wr)
                mem_q[ptr_q][idx_q] <= req.data[WORD_W-1:0];
        end
    end

    always_comb begin
        if (req.sel == SEL_WIDX)
            rd_val = WORD_W'(idx_q);
        else
            rd_val = mem_q[ptr_q][idx_q];
    end

    p_ptr_clear_r5: assert property (@(posedge clk) disable iff (rst)
        hit_idx_wr |=> (ptr_q == '0));

    p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (hit_dat && !hit_idx_wr) |=> (ptr_q == $past(ptr_q) + PW'(1)));

    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!hit_dat && !hit_idx_wr) |=> $stable(ptr_q));

endmodule

// File: rtl/cfg_index_bank.sv
module cfg_index_bank
    import cfg_bank_pkg::*;
#(
    parameter int BYTE_DEPTH = 256,
    parameter int WORD_DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  acc_addr,
    input  logic        acc_wr,
    input  logic        acc_rd,
    input  logic [15:0] acc_wdata,
    output logic [15:0] acc_rdata
);
    acc_t              req;
    logic [BYTE_W-1:0] byte_val;
    logic [WORD_W-1:0] word_val;
    logic [BUS_W-1:0]  rdata_q;

    assign req = make_req(acc_wr, acc_rd, acc_addr, acc_wdata);

    cfg_byte_file #(.DEPTH(BYTE_DEPTH)) u_bytes (
        .clk(clk), .rst(rst), .req(req), .rd_val(byte_val)
    );

    cfg_word_file #(.DEPTH(WORD_DEPTH)) u_words (
        .clk(clk), .rst(rst), .req(req), .rd_val(word_val)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (req.rd) begin
            if (req.sel == SEL_BIDX || req.sel == SEL_BDAT)
                rdata_q <= BUS_W'(byte_val);
            else
                rdata_q <= BUS_W'(word_val);
        end
    end

    assign acc_rdata = rdata_q;

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(acc_rd && !acc_wr) |=> $stable(acc_rdata));

    p_conflict_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && acc_wr) |=> $stable(acc_rdata));

endmodule

// File: tb/sim_cfg_index_bank.sv
`timescale 1ns/1ps
module sim_cfg_index_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  acc_addr = '0;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cfg_index_bank u0 (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .acc_rd(acc_rd), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        acc_addr = a; acc_rd = 1'b1;
        @(negedge clk);
        acc_rd = 1'b0;
        d = acc_rdata;
    endtask

    task automatic bus_both(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        acc_addr = a; acc_wdata = d; acc_wr = 1'b1; acc_rd = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R8 reset rdata", acc_rdata, 16'h0);
        bus_rd(2'd0, v); check("R4 byte index", v, 16'h0);
        bus_rd(2'd2, v); check("R7 word index", v, 16'h0);
        for (int k = 0; k < 4; k++) begin
            bus_rd(2'd3, v); check("R7 word entry", v, 16'h0);
        end
        bus_wr(2'd0, 16'h00C3);
        bus_rd(2'd1, v); check("R4 byte entry zero", v, 16'h0);
        bus_rd(2'd0, v); check("R1 index readback", v, 16'h00C3);
    endtask

    task automatic t_bump();
        logic [15:0] v;
        logic [7:0] exp = 8'h10;
        bus_wr(2'd0, 16'h0000);
        bus_rd(2'd0, v); check("R10 index read no effect", v, 16'h0);
        for (int k = 0; k < 5; k++) begin
            bus_rd(2'd1, v); check("R3 entry0 bump", v, {8'h0, exp});
            exp = exp + 8'h40;
        end
        bus_wr(2'd1, 16'h0005);
        bus_rd(2'd1, v); check("R3 write entry0", v, 16'h0005);
        bus_rd(2'd1, v); check("R3 bump after write", v, 16'h0045);
    endtask

    task automatic t_bytes();
        logic [15:0] v;
        bus_wr(2'd0, 16'h0011); bus_wr(2'd1, 16'hAB5A);
        bus_wr(2'd0, 16'h00FF); bus_wr(2'd1, 16'h0077);
        bus_wr(2'd0, 16'h0012); bus_wr(2'd1, 16'h0033);
        bus_wr(2'd0, 16'h0011);
        bus_rd(2'd1, v); check("R2 byte entry 0x11", v, 16'h005A);
        bus_rd(2'd1, v); check("R2 byte reread stable", v, 16'h005A);
        bus_wr(2'd0, 16'h00FF);
        bus_rd(2'd1, v); check("R2 byte entry 0xFF", v, 16'h0077);
        bus_wr(2'd0, 16'h0012);
        bus_rd(2'd1, v); check("R2 byte entry 0x12", v, 16'h0033);
    endtask

    task automatic t_words();
        logic [15:0] v;
        bus_wr(2'd2, 16'h0042);
        bus_wr(2'd3, 16'h1111); bus_wr(2'd3, 16'h2222);
        bus_wr(2'd3, 16'h3333); bus_wr(2'd3, 16'h4444);
        bus_wr(2'd2, 16'h0043);
        bus_wr(2'd3, 16'hBEEF);
        bus_wr(2'd2, 16'h0042);
        bus_rd(2'd2, v); check("R5 word index readback", v, 16'h0042);
        bus_rd(2'd3, v); check("R6 word 0", v, 16'h1111);
        bus_rd(2'd3, v); check("R6 word 1", v, 16'h2222);
        bus_rd(2'd3, v); check("R6 word 2", v, 16'h3333);
        bus_rd(2'd3, v); check("R6 word 3", v, 16'h4444);
        bus_rd(2'd3, v); check("R6 wrap to word 0", v, 16'h1111);
        bus_wr(2'd2, 16'h0042);
        bus_rd(2'd3, v); check("R5 pointer cleared", v, 16'h1111);
        bus_wr(2'd2, 16'h0043);
        bus_rd(2'd3, v); check("R6 other index", v, 16'hBEEF);
    endtask

    task automatic t_hold();
        logic [15:0] v;
        bus_wr(2'd2, 16'h0042);
        bus_rd(2'd3, v);
        bus_wr(2'd0, 16'h0099);
        repeat (3) @(negedge clk);
        check("R8 rdata holds", acc_rdata, 16'h1111);
    endtask

    task automatic t_conflict();
        logic [15:0] v;
        bus_wr(2'd2, 16'h0050);
        bus_wr(2'd3, 16'h0A0A); bus_wr(2'd3, 16'h0B0B);
        bus_wr(2'd2, 16'h0050);
        bus_rd(2'd2, v);
        bus_both(2'd3, 16'hCAFE);
        check("R9 rdata kept on word conflict", acc_rdata, 16'h0050);
        bus_rd(2'd3, v); check("R9 single pointer step", v, 16'h0B0B);
        bus_wr(2'd2, 16'h0050);
        bus_rd(2'd3, v); check("R9 conflict wrote word", v, 16'hCAFE);
        bus_wr(2'd0, 16'h0000);
        bus_both(2'd1, 16'h0022);
        check("R9 rdata kept on byte conflict", acc_rdata, 16'hCAFE);
        bus_rd(2'd1, v); check("R9 no bump on conflict", v, 16'h0022);
        bus_rd(2'd1, v); check("R3 bump follows", v, 16'h0062);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bump();
        t_bytes();
        t_words();
        t_hold();
        t_conflict();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule